// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the horizontal and vertical timing of a character-based raster display. Each enabled character clock advances a character counter across the scanline. At the end of each line, a line counter steps down the frame. From the two counters and a set of programmed timing fields, the block drives a display-enable, horizontal and vertical blanking, horizontal and vertical sync (retrace), and a latched vertical-retrace interrupt request.

The timing fields come already decoded from a register file elsewhere. The start of blanking and the start of retrace use a full-width equality compare. The end of each of those intervals compares only a few low bits of the counter, as the classic display controllers did. An end value that does not fall inside the expected window therefore ends the interval at a later point where the low bits match, which can be after the counter wraps. A line-halving mode steps the line counter only on every second scanline. A run control holds the whole timing chain at its origin while it is low.

Top module: `crtc_timing`

## Requirements
- R1: `charCount` steps by one only on a clock edge where `chEn` and `timingRun` are both 1. It returns to 0 after reaching `hTotal`+4, so a scanline lasts `hTotal`+5 character clocks.
- R2: `dispEn` is 1 exactly when the block was running in the previous cycle and `charCount` <= `hDispEnd` and `lineCount` <= `vDispEnd`. The visible width is therefore `hDispEnd`+1 characters.
- R3: `hBlank` becomes 1 on the enabled edge where `charCount` equals `hBlankStart`. It becomes 0 on the enabled edge where `charCount[5:0]` equals the 6-bit `hBlankEnd`. If both match on the same edge, the start wins.
- R4: `hSync` becomes 1 on the enabled edge where `charCount` equals `hSyncStart`. It becomes 0 on the enabled edge where `charCount[4:0]` equals the 5-bit `hSyncEnd`. If both match on the same edge, the start wins.
- R5: `lineCount` advances on the enabled edge that ends a line. It returns to 0 after `vTotal`+1, so a frame holds `vTotal`+2 line steps.
- R6: While `lineDiv2` is 1, `lineCount` advances only on every second line end. A line-parity bit toggles on each line end and is 0 after reset or while the block is stopped.
- R7: `vBlank` is updated on each line-counter step from the new line number. It becomes 1 when the new number equals the 10-bit `vBlankStart`, otherwise it becomes 0 when the low 7 bits of the new number equal `vBlankEnd`.
- R8: `vSync` is updated on each line-counter step from the new line number. It becomes 1 when the new number equals the 10-bit `vSyncStart`, otherwise it becomes 0 when the low 4 bits of the new number equal `vSyncEnd`.
- R9: `irqReq` is set on the edge where `vSync` is set, unless `irqDisable` is 1. Once set, it stays set until an edge with `irqClear` = 1 and no new set event. A new set event wins over a clear on the same edge.
- R10: While `timingRun` is 0, both counters, the line parity and all blank and sync flags are forced to 0 on every edge. `irqReq` keeps its value.
- R11: After `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEn | input | 1 | Character-clock enable |
| timingRun | input | 1 | 0 holds the timing chain at its origin |
| lineDiv2 | input | 1 | Step the line counter every second scanline |
| hTotal | input | 8 | Scanline length minus 5 |
| hDispEnd | input | 8 | Last visible character |
| hBlankStart | input | 8 | Character where horizontal blanking begins |
| hBlankEnd | input | 6 | Low-bit match value that ends horizontal blanking |
| hSyncStart | input | 8 | Character where horizontal retrace begins |
| hSyncEnd | input | 5 | Low-bit match value that ends horizontal retrace |
| vTotal | input | 10 | Frame line count minus 2 |
| vDispEnd | input | 10 | Last visible line |
| vBlankStart | input | 10 | Line where vertical blanking begins |
| vBlankEnd | input | 7 | Low-bit match value that ends vertical blanking |
| vSyncStart | input | 10 | Line where vertical retrace begins |
| vSyncEnd | input | 4 | Low-bit match value that ends vertical retrace |
| irqDisable | input | 1 | Blocks new retrace interrupt requests |
| irqClear | input | 1 | Clears a pending interrupt request |
| charCount | output | 9 | Character counter |
| lineCount | output | 10 | Line counter |
| dispEn | output | 1 | Display enable |
| hBlank | output | 1 | Horizontal blanking |
| hSync | output | 1 | Horizontal retrace |
| vBlank | output | 1 | Vertical blanking |
| vSync | output | 1 | Vertical retrace |
| irqReq | output | 1 | Pending vertical-retrace interrupt |

## Verification
Several properties are checked on every cycle:
- the character counter holds while the enable is low and never passes its wrap value;
- a stopped chain sits at the origin with all flags low;
- a rising blank or sync flag coincides with its full-width start match;
- a pending interrupt survives until it is cleared.

The points where blanking and retrace end under partial-width matching can only be shown by the bench's scenarios. These include an interval that runs across a line or frame wrap, and a retrace that ends early on a low-bit alias. The same holds for line halving, gapped enables and interrupt masking. There, a behavioural model predicts every output on every clock.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  // Strobes passed from the control decoder to the counter/flag datapath.
  typedef struct packed {
    logic step;       // enabled character clock while running
    logic lineEnd;    // last character of the scanline
    logic lineAdv;    // line counter steps on this edge
    logic vWrap;      // line counter returns to zero
    logic hBlankSet;
    logic hBlankClr;
    logic hSyncSet;
    logic hSyncClr;
    logic vBlankSet;
    logic vBlankClr;
    logic vSyncSet;
    logic vSyncClr;
    logic irqSet;
  } crtcStrobes_t;
endpackage

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int HW   = 8,
  parameter int VW   = 10,
  parameter int HBEW = 6,
  parameter int HSEW = 5,
  parameter int VBEW = 7,
  parameter int VSEW = 4
) (
  input  logic            chEn,
  input  logic            timingRun,
  input  logic            lineDiv2,
  input  logic            halfLine,
  input  logic [HW:0]     charCount,
  input  logic [VW-1:0]   lineCount,
  input  logic [HW-1:0]   hTotal,
  input  logic [HW-1:0]   hBlankStart,
  input  logic [HBEW-1:0] hBlankEnd,
  input  logic [HW-1:0]   hSyncStart,
  input  logic [HSEW-1:0] hSyncEnd,
  input  logic [VW-1:0]   vTotal,
  input  logic [VW-1:0]   vBlankStart,
  input  logic [VBEW-1:0] vBlankEnd,
  input  logic [VW-1:0]   vSyncStart,
  input  logic [VSEW-1:0] vSyncEnd,
  input  logic            irqDisable,
  output crtcStrobes_t    st
);
  localparam int HCW = HW + 1;

  logic [HCW-1:0] hLast;
  logic [VW-1:0]  vLast;
  logic [VW-1:0]  lineNext;

  always_comb begin
    hLast = HCW'(hTotal) + HCW'(4);
    vLast = vTotal + VW'(1);

    st.step    = chEn & timingRun;
    st.lineEnd = st.step & (charCount == hLast);
    st.lineAdv = st.lineEnd & (~lineDiv2 | halfLine);
    st.vWrap   = lineCount == vLast;
    lineNext   = st.vWrap ? '0 : lineCount + VW'(1);

    // Full-width start, partial-width end
    st.hBlankSet = st.step & (charCount == HCW'(hBlankStart));
    st.hBlankClr = st.step & (charCount[HBEW-1:0] == hBlankEnd);
    st.hSyncSet  = st.step & (charCount == HCW'(hSyncStart));
    st.hSyncClr  = st.step & (charCount[HSEW-1:0] == hSyncEnd);

    st.vBlankSet = st.lineAdv & (lineNext == vBlankStart);
    st.vBlankClr = st.lineAdv & (lineNext[VBEW-1:0] == vBlankEnd);
    st.vSyncSet  = st.lineAdv & (lineNext == vSyncStart);
    st.vSyncClr  = st.lineAdv & (lineNext[VSEW-1:0] == vSyncEnd);
    st.irqSet    = st.vSyncSet & ~irqDisable;
  end
endmodule

// File: rtl/crtc_dp.sv
module crtc_dp
  import crtc_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          timingRun,
  input  logic          lineDiv2,
  input  logic          irqClear,
  input  logic [HW-1:0] hDispEnd,
  input  logic [VW-1:0] vDispEnd,
  input  crtcStrobes_t  st,
  output logic [HW:0]   charCount,
  output logic [VW-1:0] lineCount,
  output logic          halfLine,
  output logic          dispEn,
  output logic          hBlank,
  output logic          hSync,
  output logic          vBlank,
  output logic          vSync,
  output logic          irqReq
);
  localparam int HCW = HW + 1;

  logic live;

  always_ff @(posedge clk) begin
    if (!rstN || !timingRun) begin
      charCount <= '0;
      lineCount <= '0;
      halfLine  <= 1'b0;
      hBlank    <= 1'b0;
      hSync     <= 1'b0;
      vBlank    <= 1'b0;
      vSync     <= 1'b0;
    end else if (st.step) begin
      charCount <= st.lineEnd ? '0 : charCount + HCW'(1);
      if (st.lineEnd) halfLine <= lineDiv2 & ~halfLine;
      if (st.lineAdv) lineCount <= st.vWrap ? '0 : lineCount + VW'(1);
      if (st.hBlankSet)      hBlank <= 1'b1;
      else if (st.hBlankClr) hBlank <= 1'b0;
      if (st.hSyncSet)       hSync  <= 1'b1;
      else if (st.hSyncClr)  hSync  <= 1'b0;
      if (st.vBlankSet)      vBlank <= 1'b1;
      else if (st.vBlankClr) vBlank <= 1'b0;
      if (st.vSyncSet)       vSync  <= 1'b1;
      else if (st.vSyncClr)  vSync  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      live   <= 1'b0;
    end else begin
      live <= timingRun;
      if (st.irqSet)     irqReq <= 1'b1;
      else if (irqClear) irqReq <= 1'b0;
    end
  end

  assign dispEn = live & (charCount <= HCW'(hDispEnd)) & (lineCount <= vDispEnd);
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chEn,
  input  logic          timingRun,
  input  logic          lineDiv2,
  input  logic [HW-1:0] hTotal,
  input  logic [HW-1:0] hDispEnd,
  input  logic [HW-1:0] hBlankStart,
  input  logic [5:0]    hBlankEnd,
  input  logic [HW-1:0] hSyncStart,
  input  logic [4:0]    hSyncEnd,
  input  logic [VW-1:0] vTotal,
  input  logic [VW-1:0] vDispEnd,
  input  logic [VW-1:0] vBlankStart,
  input  logic [6:0]    vBlankEnd,
  input  logic [VW-1:0] vSyncStart,
  input  logic [3:0]    vSyncEnd,
  input  logic          irqDisable,
  input  logic          irqClear,
  output logic [HW:0]   charCount,
  output logic [VW-1:0] lineCount,
  output logic          dispEn,
  output logic          hBlank,
  output logic          hSync,
  output logic          vBlank,
  output logic          vSync,
  output logic          irqReq
);
  crtcStrobes_t st;
  logic halfLine;

  crtc_ctrl #(.HW(HW), .VW(VW), .HBEW(6), .HSEW(5), .VBEW(7), .VSEW(4)) u_ctrl (
    .chEn(chEn), .timingRun(timingRun), .lineDiv2(lineDiv2), .halfLine(halfLine),
    .charCount(charCount), .lineCount(lineCount),
    .hTotal(hTotal), .hBlankStart(hBlankStart), .hBlankEnd(hBlankEnd),
    .hSyncStart(hSyncStart), .hSyncEnd(hSyncEnd),
    .vTotal(vTotal), .vBlankStart(vBlankStart), .vBlankEnd(vBlankEnd),
    .vSyncStart(vSyncStart), .vSyncEnd(vSyncEnd),
    .irqDisable(irqDisable), .st(st)
  );

  crtc_dp #(.HW(HW), .VW(VW)) u_dp (
    .clk(clk), .rstN(rstN), .timingRun(timingRun), .lineDiv2(lineDiv2),
    .irqClear(irqClear), .hDispEnd(hDispEnd), .vDispEnd(vDispEnd), .st(st),
    .charCount(charCount), .lineCount(lineCount), .halfLine(halfLine),
    .dispEn(dispEn), .hBlank(hBlank), .hSync(hSync), .vBlank(vBlank),
    .vSync(vSync), .irqReq(irqReq)
  );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          chEn,
  input logic          timingRun,
  input logic [HW-1:0] hTotal,
  input logic [HW-1:0] hBlankStart,
  input logic [HW-1:0] hSyncStart,
  input logic [VW-1:0] vSyncStart,
  input logic          irqDisable,
  input logic          irqClear,
  input logic [HW:0]   charCount,
  input logic [VW-1:0] lineCount,
  input logic          hBlank,
  input logic          hSync,
  input logic          vBlank,
  input logic          vSync,
  input logic          irqReq
);
  assert_hold_no_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!chEn && timingRun) |=> $stable(charCount));

  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    timingRun |-> (int'(charCount) <= int'(hTotal) + 4));

  assert_hblank_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hBlank) |-> ($past(charCount) == {1'b0, $past(hBlankStart)}));

  assert_hsync_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hSync) |-> ($past(charCount) == {1'b0, $past(hSyncStart)}));

  assert_vsync_rise_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> (lineCount == vSyncStart));

  assert_irq_pending_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClear) |=> irqReq);

  assert_irq_rise_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> (vSync && !$past(irqDisable) && lineCount == vSyncStart));

  assert_stopped_origin_R10: assert property (@(posedge clk) disable iff (!rstN)
    !timingRun |=> (charCount == '0 && lineCount == '0 && !hBlank && !hSync && !vBlank && !vSync));
endmodule

bind crtc_timing crtc_timing_chk #(.HW(HW), .VW(VW)) u_chk (.*);

// File: tb/tb_crtc_timing.sv
module tb_crtc_timing;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chEn = 1'b0, timingRun = 1'b0, lineDiv2 = 1'b0;
  logic [7:0] hTotal, hDispEnd, hBlankStart, hSyncStart;
  logic [5:0] hBlankEnd;
  logic [4:0] hSyncEnd;
  logic [9:0] vTotal, vDispEnd, vBlankStart, vSyncStart;
  logic [6:0] vBlankEnd;
  logic [3:0] vSyncEnd;
  logic irqDisable = 1'b0, irqClear = 1'b0;
  logic [8:0] charCount;
  logic [9:0] lineCount;
  logic dispEn, hBlank, hSync, vBlank, vSync, irqReq;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_timing dut (.*);

  // Behavioural reference state
  int mHc = 0, mVc = 0;
  bit mHalf = 0, mLive = 0, mHb = 0, mHs = 0, mVb = 0, mVs = 0, mIrq = 0;

  always @(posedge clk) begin
    int nh, nv;
    bit lineEnd, adv, irqEv, nHb, nHs, nVb, nVs, nHalf;
    irqEv = 0;
    if (!rstN) begin
      mHc <= 0; mVc <= 0; mHalf <= 0; mLive <= 0;
      mHb <= 0; mHs <= 0; mVb <= 0; mVs <= 0; mIrq <= 0;
    end else begin
      mLive <= timingRun;
      if (!timingRun) begin
        mHc <= 0; mVc <= 0; mHalf <= 0; mHb <= 0; mHs <= 0; mVb <= 0; mVs <= 0;
      end else if (chEn) begin
        lineEnd = (mHc == int'(hTotal) + 4);
        nh = lineEnd ? 0 : mHc + 1;
        nHalf = lineEnd ? (lineDiv2 && !mHalf) : mHalf;
        adv = lineEnd && (!lineDiv2 || mHalf);
        nv = mVc;
        if (adv) nv = (mVc == int'(vTotal) + 1) ? 0 : mVc + 1;
        nHb = mHb; nHs = mHs; nVb = mVb; nVs = mVs;
        if (mHc == int'(hBlankStart)) nHb = 1;
        else if ((mHc % 64) == int'(hBlankEnd)) nHb = 0;
        if (mHc == int'(hSyncStart)) nHs = 1;
        else if ((mHc % 32) == int'(hSyncEnd)) nHs = 0;
        if (adv) begin
          if (nv == int'(vBlankStart)) nVb = 1;
          else if ((nv % 128) == int'(vBlankEnd)) nVb = 0;
          if (nv == int'(vSyncStart)) begin
            nVs = 1;
            irqEv = !irqDisable;
          end else if ((nv % 16) == int'(vSyncEnd)) nVs = 0;
        end
        mHc <= nh; mVc <= nv; mHalf <= nHalf;
        mHb <= nHb; mHs <= nHs; mVb <= nVb; mVs <= nVs;
      end
      if (irqEv) mIrq <= 1;
      else if (irqClear) mIrq <= 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  // Compare every output on the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        // R11: reset state
        chk("R11", "reset outputs", int'({charCount, lineCount, dispEn, hBlank, hSync, vBlank, vSync, irqReq}), 0);
      end else begin
        chk("R1", "charCount", int'(charCount), mHc);
        chk("R5", "lineCount", int'(lineCount), mVc);
        chk("R2", "dispEn", int'(dispEn),
            int'(mLive && mHc <= int'(hDispEnd) && mVc <= int'(vDispEnd)));
        chk("R3", "hBlank", int'(hBlank), int'(mHb));
        chk("R4", "hSync", int'(hSync), int'(mHs));
        chk("R7", "vBlank", int'(vBlank), int'(mVb));
        chk("R8", "vSync", int'(vSync), int'(mVs));
        chk("R9", "irqReq", int'(irqReq), int'(mIrq));
      end
    end
  end

  // gap: 0 = enable every cycle, 1 = enable two of three cycles
  task automatic runFor(int n, int gap, int clrEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chEn = (gap == 0) ? 1'b1 : (i % 3 != 0);
      irqClear = (clrEvery > 0) && (i % clrEvery == clrEvery - 1);
    end
  endtask

  task automatic stopChain(int n);
    // R10: stopping forces the origin, irqReq untouched
    @(negedge clk); #1;
    timingRun = 1'b0; irqClear = 1'b0;
    runFor(n, 0, 0);
  endtask

  initial begin
    hTotal = 8'd10; hDispEnd = 8'd7; hBlankStart = 8'd9; hBlankEnd = 6'd13;
    hSyncStart = 8'd10; hSyncEnd = 5'd12;
    vTotal = 10'd6; vDispEnd = 10'd4; vBlankStart = 10'd5; vBlankEnd = 7'd7;
    vSyncStart = 10'd6; vSyncEnd = 4'd7;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    timingRun = 1'b1;
    // R1 R3 R4 R5 R7 R8 R9: plain frames, pending interrupt left uncleared
    runFor(400, 0, 0);
    // R1: gapped character enable with periodic clears of the request
    runFor(400, 1, 97);
    // R9: masked interrupts
    irqDisable = 1'b1;
    runFor(260, 0, 40);
    irqDisable = 1'b0;
    // R6: line halving
    lineDiv2 = 1'b1;
    runFor(500, 0, 0);
    lineDiv2 = 1'b0;
    stopChain(20);
    // R3 R4 R7 R8: intervals that end on low-bit aliases or across a wrap
    hTotal = 8'd40; hDispEnd = 8'd31; hBlankStart = 8'd36; hBlankEnd = 6'd2;
    hSyncStart = 8'd5; hSyncEnd = 5'd2;
    vTotal = 10'd20; vDispEnd = 10'd15; vBlankStart = 10'd18; vBlankEnd = 7'd1;
    vSyncStart = 10'd19; vSyncEnd = 4'd2;
    runFor(5, 0, 0);
    timingRun = 1'b1;
    runFor(2100, 0, 300);
    // R10: stop in mid-frame
    stopChain(15);
    timingRun = 1'b1;
    runFor(200, 1, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule